// File: doc/BRIEF.md
# Update-Protocol Snooping Coherence Controller

This block keeps one direct-mapped, write-back cache coherent with its peers on a shared snooping bus. It follows an update discipline. When a cache writes a line that other caches also hold, it broadcasts the new word on the bus. Every other holder merges that word into its own copy, so no copy is ever thrown away because of a remote write. Each resident line is in one of four states: exclusive-clean (`LN_EXC`), shared-clean (`LN_SC`), shared-owner (`LN_SM`, dirty and responsible for memory) or modified-private (`LN_MOD`). An empty way is `LN_INV`, and that state is reached only through reset or a local eviction.

The processor side takes one request at a time. A request is a read, a write or an evict of an address, and completion is signalled with a one-cycle `cpu_done` pulse. The master side presents a fill read, an update broadcast or a write-back, and holds it until `bm_ack`. `bm_ack` returns the wired "some other cache holds this" sense and the fill word. The snoop side watches other caches' reads and updates. On every such transaction it drives the shared sense and, when this cache owns the dirty copy, the supplied data. Arbitration lies outside the block, which is why no peer snoop can arrive while this block holds the bus.

The control state machine has five states. `FS_IDLE` accepts a request. `FS_EVAL` looks the request up in the line store, using the line state after any snoop of that cycle has been applied. `FS_WB_WAIT` writes back a dirty line. `FS_RD_WAIT` fills the line. `FS_UPD_WAIT` broadcasts an update. The line transitions are as follows. A local read that misses goes from INV to EXC or SC. A local write goes from EXC or MOD to MOD with no bus activity, and from SC or SM to SM or MOD through an update. A snooped read takes EXC to SC and MOD to SM. A snooped update takes SM to SC and merges the new word into SC. A local evict takes any state to INV, with a write-back only from SM or MOD.

Top module: `dragon_snoop_ctrl`

## Requirements
- R1: After reset, every line is empty, `bm_cmd` is none (0), `cpu_done` is low, and a snoop to any address sees `sn_shared` low.
- R2: A read miss whose fill returns `bm_shared`=0 installs the line as exclusive-clean. The read returns the fill word, and a later write to that line causes no bus command.
- R3: A read miss whose fill returns `bm_shared`=1 installs the line as shared-clean. A line held exclusive-clean that snoops a peer read becomes shared-clean, so the next local write to it broadcasts an update.
- R4: A local write to a shared-clean or shared-owner line issues an update (`bm_cmd`=2) carrying the new word on `bm_data`. If `bm_shared`=1 at the ack, the line becomes shared-owner.
- R5: A read hit in any resident state completes with the line's word and issues no bus command.
- R6: A snooped read (`sn_cmd`=1) that hits a shared-owner or modified-private line asserts `sn_shared` and `sn_supply` and drives the line's word on `sn_sdata`. A modified-private line becomes shared-owner, so a later local write broadcasts an update.
- R7: A local write to an exclusive-clean or modified-private line leaves it modified-private and issues no bus command.
- R8: An update acknowledged with `bm_shared`=0 leaves the writer modified-private.
- R9: A snooped update (`sn_cmd`=2) that hits merges `sn_data` into the line and never empties it. A shared-owner line hands ownership away and becomes shared-clean, so it stops asserting `sn_supply`.
- R10: Evicting (`cpu_op`=2) a shared-owner or modified-private line issues a write-back (`bm_cmd`=3) carrying the line's word. Evicting an exclusive-clean or shared-clean line, or an absent address, issues nothing.
- R11: A miss whose index holds a dirty line of another tag first writes that line back, then fills. A write miss fills first and then completes as a write to the filled line.
- R12: A snoop that hits the pending request's line in the evaluation cycle is applied first, and the request is evaluated again in the next cycle against the updated line.
- R13: A bus command and its address and data stay unchanged from the cycle they appear until the cycle `bm_ack` is sampled.
- R14: `sn_shared` is asserted for a snooped read or update exactly when the addressed line is resident with a matching tag. Address bits [1:0] select the line and [3:2] form the tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Request strobe, sampled in idle |
| cpu_op | input | 2 | 0 read, 1 write, 2 evict, 3 no-op |
| cpu_addr | input | ADDR_W | Request address |
| cpu_wdata | input | DATA_W | Write word |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read result, valid with `cpu_done` |
| bm_cmd | output | 2 | Master command: 0 none, 1 fill read, 2 update, 3 write-back |
| bm_addr | output | ADDR_W | Master address |
| bm_data | output | DATA_W | Update or write-back word |
| bm_ack | input | 1 | Master command completed this cycle |
| bm_shared | input | 1 | Wired shared sense returned with the ack |
| bm_rdata | input | DATA_W | Fill word returned with the ack |
| sn_cmd | input | 2 | Peer transaction: 0 none, 1 read, 2 update |
| sn_addr | input | ADDR_W | Peer address |
| sn_data | input | DATA_W | Peer update word |
| sn_shared | output | 1 | This cache holds the snooped line |
| sn_supply | output | 1 | This cache is owner and supplies data |
| sn_sdata | output | DATA_W | Supplied word |

## Verification
A peer's update and a local read of the same line can meet in the evaluation cycle. The bench provokes this by driving a snooped update to the pending line on the cycle after the read is accepted. A correct design must return the peer's word rather than the stale local word. It must also stop asserting `sn_supply` for that line afterwards, because ownership moved to the peer. Fill and update completions are both judged by what happens next at the ports: whether a following local write is silent or broadcast, and whether a snooped read is answered with supplied data.

// File: rtl/dragon_pkg.sv
package dragon_pkg;

    typedef enum logic [2:0] {
        LN_INV = 3'd0,
        LN_EXC = 3'd1,
        LN_SC  = 3'd2,
        LN_SM  = 3'd3,
        LN_MOD = 3'd4
    } line_st_e;

    typedef enum logic [1:0] {
        BC_NONE = 2'd0,
        BC_RD   = 2'd1,
        BC_UPD  = 2'd2,
        BC_WB   = 2'd3
    } bus_cmd_e;

    typedef enum logic [1:0] {
        OP_RD  = 2'd0,
        OP_WR  = 2'd1,
        OP_EV  = 2'd2,
        OP_NOP = 2'd3
    } cpu_op_e;

    typedef enum logic [2:0] {
        FS_IDLE     = 3'd0,
        FS_EVAL     = 3'd1,
        FS_WB_WAIT  = 3'd2,
        FS_RD_WAIT  = 3'd3,
        FS_UPD_WAIT = 3'd4
    } fsm_st_e;

endpackage

// File: rtl/dgn_line_store.sv
module dgn_line_store
    import dragon_pkg::*;
#(
    parameter int LINES = 4,
    parameter int TAG_W = 2,
    parameter int DATA_W = 8,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output line_st_e          rd_st,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  line_st_e          wr_st,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    input  bus_cmd_e          sn_cmd,
    input  logic [IDX_W-1:0]  sn_idx,
    input  logic [TAG_W-1:0]  sn_tag,
    input  logic [DATA_W-1:0] sn_data,
    output logic              sn_hit,
    output logic              sn_supply,
    output logic [DATA_W-1:0] sn_sdata
);

    line_st_e          st_q   [LINES];
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];
    logic [LINES-1:0]  snp_here;
    logic [LINES-1:0]  fsm_here;

    assign rd_st   = st_q[rd_idx];
    assign rd_tag  = tag_q[rd_idx];
    assign rd_data = data_q[rd_idx];

    assign sn_hit = (sn_cmd == BC_RD || sn_cmd == BC_UPD) &&
                    (st_q[sn_idx] != LN_INV) && (tag_q[sn_idx] == sn_tag);
    assign sn_supply = sn_hit && (sn_cmd == BC_RD) &&
                       (st_q[sn_idx] == LN_SM || st_q[sn_idx] == LN_MOD);
    assign sn_sdata = sn_supply ? data_q[sn_idx] : '0;

    for (genvar g = 0; g < LINES; g++) begin : g_sel
        assign snp_here[g] = sn_hit && (sn_idx == IDX_W'(g));
        assign fsm_here[g] = wr_en && (wr_idx == IDX_W'(g));
    end

    // snoop updates take priority over controller writes to the same line
    always_ff @(posedge clk) begin
        for (int i = 0; i < LINES; i++) begin
            if (!rst_n) begin
                st_q[i]   <= LN_INV;
                tag_q[i]  <= '0;
                data_q[i] <= '0;
            end else if (snp_here[i]) begin
                if (sn_cmd == BC_RD) begin
                    unique case (st_q[i])
                        LN_EXC:  st_q[i] <= LN_SC;
                        LN_MOD:  st_q[i] <= LN_SM;
                        default: st_q[i] <= st_q[i];
                    endcase
                end else begin
                    data_q[i] <= sn_data;
                    st_q[i]   <= LN_SC;
                end
            end else if (fsm_here[i]) begin
                st_q[i]   <= wr_st;
                tag_q[i]  <= wr_tag;
                data_q[i] <= wr_data;
            end
        end
    end

    p_snrd_exc_to_sc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sn_hit && sn_cmd == BC_RD && st_q[sn_idx] == LN_EXC)
        |=> st_q[$past(sn_idx)] == LN_SC);

    p_snrd_mod_to_sm_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sn_hit && sn_cmd == BC_RD && st_q[sn_idx] == LN_MOD)
        |=> st_q[$past(sn_idx)] == LN_SM);

    p_snupd_handoff_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sn_hit && sn_cmd == BC_UPD)
        |=> (st_q[$past(sn_idx)] == LN_SC) &&
            (data_q[$past(sn_idx)] == $past(sn_data)));

    p_supply_owner_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sn_supply |-> (sn_hit && sn_cmd == BC_RD));

endmodule

// File: rtl/dgn_ctrl_fsm.sv
module dgn_ctrl_fsm
    import dragon_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int IDX_W = 2,
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  cpu_op_e           cpu_op,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic [IDX_W-1:0]  ls_idx,
    input  line_st_e          ls_st,
    input  logic [TAG_W-1:0]  ls_tag,
    input  logic [DATA_W-1:0] ls_data,
    output logic              wr_en,
    output line_st_e          wr_st,
    output logic [TAG_W-1:0]  wr_tag,
    output logic [DATA_W-1:0] wr_data,
    input  logic              sn_hit,
    input  logic [IDX_W-1:0]  sn_idx,
    output bus_cmd_e          bm_cmd,
    output logic [ADDR_W-1:0] bm_addr,
    output logic [DATA_W-1:0] bm_data,
    input  logic              bm_ack,
    input  logic              bm_shared,
    input  logic [DATA_W-1:0] bm_rdata
);

    fsm_st_e           st_q, st_d;
    cpu_op_e           op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wd_q;
    logic              fill_q, fill_d;
    logic              fin;
    logic              fin_rd;
    logic [DATA_W-1:0] fin_data;
    logic              done_q;
    logic [DATA_W-1:0] rdata_q;

    logic [TAG_W-1:0]  req_tag;
    logic              hit;
    logic              dirty;
    logic              collide;

    assign ls_idx  = addr_q[IDX_W-1:0];
    assign req_tag = addr_q[ADDR_W-1:IDX_W];
    assign hit     = (ls_st != LN_INV) && (ls_tag == req_tag);
    assign dirty   = (ls_st == LN_SM) || (ls_st == LN_MOD);
    assign collide = (st_q == FS_EVAL) && sn_hit && (sn_idx == ls_idx);

    // state register and request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= FS_IDLE;
            op_q    <= OP_NOP;
            addr_q  <= '0;
            wd_q    <= '0;
            fill_q  <= 1'b0;
            done_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            st_q   <= st_d;
            fill_q <= fill_d;
            done_q <= fin;
            if (fin && fin_rd) rdata_q <= fin_data;
            if (st_q == FS_IDLE && cpu_req && cpu_op != OP_NOP) begin
                op_q   <= cpu_op;
                addr_q <= cpu_addr;
                wd_q   <= cpu_wdata;
            end
        end
    end

    // next state
    always_comb begin
        st_d     = st_q;
        fill_d   = fill_q;
        fin      = 1'b0;
        fin_rd   = 1'b0;
        fin_data = ls_data;
        unique case (st_q)
            FS_IDLE: begin
                if (cpu_req && cpu_op != OP_NOP) st_d = FS_EVAL;
            end
            FS_EVAL: begin
                if (collide) begin
                    st_d = FS_EVAL;
                end else if (op_q == OP_EV) begin
                    if (hit && dirty) begin
                        st_d   = FS_WB_WAIT;
                        fill_d = 1'b0;
                    end else begin
                        st_d = FS_IDLE;
                        fin  = 1'b1;
                    end
                end else if (hit) begin
                    if (op_q == OP_RD) begin
                        st_d   = FS_IDLE;
                        fin    = 1'b1;
                        fin_rd = 1'b1;
                    end else if (ls_st == LN_EXC || ls_st == LN_MOD) begin
                        st_d = FS_IDLE;
                        fin  = 1'b1;
                    end else begin
                        st_d = FS_UPD_WAIT;
                    end
                end else if (dirty) begin
                    st_d   = FS_WB_WAIT;
                    fill_d = 1'b1;
                end else begin
                    st_d = FS_RD_WAIT;
                end
            end
            FS_WB_WAIT: begin
                if (bm_ack) begin
                    if (fill_q) begin
                        st_d = FS_RD_WAIT;
                    end else begin
                        st_d = FS_IDLE;
                        fin  = 1'b1;
                    end
                    fill_d = 1'b0;
                end
            end
            FS_RD_WAIT: begin
                if (bm_ack) begin
                    if (op_q == OP_RD) begin
                        st_d     = FS_IDLE;
                        fin      = 1'b1;
                        fin_rd   = 1'b1;
                        fin_data = bm_rdata;
                    end else begin
                        st_d = FS_EVAL;
                    end
                end
            end
            FS_UPD_WAIT: begin
                if (bm_ack) begin
                    st_d = FS_IDLE;
                    fin  = 1'b1;
                end
            end
            default: st_d = FS_IDLE;
        endcase
    end

    // outputs: bus master command and line store write port
    always_comb begin
        bm_cmd  = BC_NONE;
        bm_addr = '0;
        bm_data = '0;
        wr_en   = 1'b0;
        wr_st   = ls_st;
        wr_tag  = ls_tag;
        wr_data = ls_data;
        unique case (st_q)
            FS_EVAL: begin
                if (!collide && hit && op_q == OP_WR &&
                    (ls_st == LN_EXC || ls_st == LN_MOD)) begin
                    wr_en   = 1'b1;
                    wr_st   = LN_MOD;
                    wr_data = wd_q;
                end else if (!collide && hit && op_q == OP_EV && !dirty) begin
                    wr_en = 1'b1;
                    wr_st = LN_INV;
                end
            end
            FS_WB_WAIT: begin
                bm_cmd  = BC_WB;
                bm_addr = {ls_tag, ls_idx};
                bm_data = ls_data;
                if (bm_ack && !fill_q) begin
                    wr_en = 1'b1;
                    wr_st = LN_INV;
                end
            end
            FS_RD_WAIT: begin
                bm_cmd  = BC_RD;
                bm_addr = addr_q;
                if (bm_ack) begin
                    wr_en   = 1'b1;
                    wr_st   = bm_shared ? LN_SC : LN_EXC;
                    wr_tag  = req_tag;
                    wr_data = bm_rdata;
                end
            end
            FS_UPD_WAIT: begin
                bm_cmd  = BC_UPD;
                bm_addr = addr_q;
                bm_data = wd_q;
                if (bm_ack) begin
                    wr_en   = 1'b1;
                    wr_st   = bm_shared ? LN_SM : LN_MOD;
                    wr_data = wd_q;
                end
            end
            default: ;
        endcase
    end

    assign cpu_done  = done_q;
    assign cpu_rdata = rdata_q;

    p_rdhit_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == FS_EVAL && op_q == OP_RD && hit && !collide)
        |=> (cpu_done && bm_cmd == BC_NONE));

    p_collide_stall_r12: assert property (@(posedge clk) disable iff (!rst_n)
        collide |=> (st_q == FS_EVAL) && $stable(addr_q));

    p_bus_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (bm_cmd != BC_NONE && !bm_ack)
        |=> (bm_cmd == $past(bm_cmd)) && (bm_addr == $past(bm_addr)) &&
            (bm_data == $past(bm_data)));

    p_upd_private_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == FS_UPD_WAIT && bm_ack && !bm_shared) |=> ls_st == LN_MOD);

    p_upd_owner_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == FS_UPD_WAIT && bm_ack && bm_shared) |=> ls_st == LN_SM);

    p_evict_wb_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == FS_EVAL && op_q == OP_EV && hit && dirty && !collide)
        |=> bm_cmd == BC_WB);

endmodule

// File: rtl/dragon_snoop_ctrl.sv
module dragon_snoop_ctrl
    import dragon_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int LINES = 4,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1,
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic [1:0]        cpu_op,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic [1:0]        bm_cmd,
    output logic [ADDR_W-1:0] bm_addr,
    output logic [DATA_W-1:0] bm_data,
    input  logic              bm_ack,
    input  logic              bm_shared,
    input  logic [DATA_W-1:0] bm_rdata,
    input  logic [1:0]        sn_cmd,
    input  logic [ADDR_W-1:0] sn_addr,
    input  logic [DATA_W-1:0] sn_data,
    output logic              sn_shared,
    output logic              sn_supply,
    output logic [DATA_W-1:0] sn_sdata
);

    logic [IDX_W-1:0]  ls_idx;
    line_st_e          ls_st;
    logic [TAG_W-1:0]  ls_tag;
    logic [DATA_W-1:0] ls_data;
    logic              wr_en;
    line_st_e          wr_st;
    logic [TAG_W-1:0]  wr_tag;
    logic [DATA_W-1:0] wr_data;
    logic              sn_hit;
    bus_cmd_e          bm_cmd_e;
    bus_cmd_e          sn_cmd_e;

    assign sn_cmd_e  = bus_cmd_e'(sn_cmd);
    assign bm_cmd    = bm_cmd_e;
    assign sn_shared = sn_hit;

    dgn_line_store #(
        .LINES (LINES),
        .TAG_W (TAG_W),
        .DATA_W(DATA_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (ls_idx),
        .rd_st    (ls_st),
        .rd_tag   (ls_tag),
        .rd_data  (ls_data),
        .wr_en    (wr_en),
        .wr_idx   (ls_idx),
        .wr_st    (wr_st),
        .wr_tag   (wr_tag),
        .wr_data  (wr_data),
        .sn_cmd   (sn_cmd_e),
        .sn_idx   (sn_addr[IDX_W-1:0]),
        .sn_tag   (sn_addr[ADDR_W-1:IDX_W]),
        .sn_data  (sn_data),
        .sn_hit   (sn_hit),
        .sn_supply(sn_supply),
        .sn_sdata (sn_sdata)
    );

    dgn_ctrl_fsm #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .IDX_W (IDX_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_req  (cpu_req),
        .cpu_op   (cpu_op_e'(cpu_op)),
        .cpu_addr (cpu_addr),
        .cpu_wdata(cpu_wdata),
        .cpu_done (cpu_done),
        .cpu_rdata(cpu_rdata),
        .ls_idx   (ls_idx),
        .ls_st    (ls_st),
        .ls_tag   (ls_tag),
        .ls_data  (ls_data),
        .wr_en    (wr_en),
        .wr_st    (wr_st),
        .wr_tag   (wr_tag),
        .wr_data  (wr_data),
        .sn_hit   (sn_hit),
        .sn_idx   (sn_addr[IDX_W-1:0]),
        .bm_cmd   (bm_cmd_e),
        .bm_addr  (bm_addr),
        .bm_data  (bm_data),
        .bm_ack   (bm_ack),
        .bm_shared(bm_shared),
        .bm_rdata (bm_rdata)
    );

    p_snoop_sense_r14: assert property (@(posedge clk) disable iff (!rst_n)
        (sn_cmd_e == BC_NONE) |-> !sn_shared && !sn_supply);

endmodule

// File: tb/test_dragon_snoop_ctrl.sv
module test_dragon_snoop_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_req = 1'b0;
    logic [1:0] cpu_op = 2'd3;
    logic [3:0] cpu_addr = '0;
    logic [7:0] cpu_wdata = '0;
    logic       cpu_done;
    logic [7:0] cpu_rdata;
    logic [1:0] bm_cmd;
    logic [3:0] bm_addr;
    logic [7:0] bm_data;
    logic       bm_ack = 1'b0;
    logic       bm_shared = 1'b0;
    logic [7:0] bm_rdata = '0;
    logic [1:0] sn_cmd = 2'd0;
    logic [3:0] sn_addr = '0;
    logic [7:0] sn_data = '0;
    logic       sn_shared;
    logic       sn_supply;
    logic [7:0] sn_sdata;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    dragon_snoop_ctrl i_dragon_snoop_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_op(cpu_op), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .bm_cmd(bm_cmd), .bm_addr(bm_addr), .bm_data(bm_data),
        .bm_ack(bm_ack), .bm_shared(bm_shared), .bm_rdata(bm_rdata),
        .sn_cmd(sn_cmd), .sn_addr(sn_addr), .sn_data(sn_data),
        .sn_shared(sn_shared), .sn_supply(sn_supply), .sn_sdata(sn_sdata)
    );

    typedef struct packed {
        logic [1:0] op;
        logic [3:0] addr;
        logic [7:0] wd;
        logic       sh;
        logic [7:0] rd;
        logic [1:0] ecmd;
        logic [7:0] ebd;
        logic [7:0] erd;
    } vec_t;

    // op: 0 rd 1 wr 2 ev; cmd: 0 none 1 rd 2 upd 3 wb
    localparam vec_t VEC [14] = '{
        '{2'd0, 4'd1, 8'h00, 1'b0, 8'h11, 2'd1, 8'h00, 8'h11}, // R2 miss, no holder
        '{2'd0, 4'd1, 8'h00, 1'b0, 8'h00, 2'd0, 8'h00, 8'h11}, // R5 hit exclusive
        '{2'd1, 4'd1, 8'h22, 1'b0, 8'h00, 2'd0, 8'h00, 8'h00}, // R7 exclusive write silent
        '{2'd0, 4'd1, 8'h00, 1'b0, 8'h00, 2'd0, 8'h00, 8'h22}, // R5 hit modified
        '{2'd2, 4'd1, 8'h00, 1'b0, 8'h00, 2'd3, 8'h22, 8'h00}, // R10 evict modified
        '{2'd0, 4'd1, 8'h00, 1'b1, 8'h33, 2'd1, 8'h00, 8'h33}, // R3 miss, shared
        '{2'd0, 4'd1, 8'h00, 1'b0, 8'h00, 2'd0, 8'h00, 8'h33}, // R5 hit shared-clean
        '{2'd1, 4'd1, 8'h44, 1'b1, 8'h00, 2'd2, 8'h44, 8'h00}, // R4 update, stays shared
        '{2'd0, 4'd1, 8'h00, 1'b0, 8'h00, 2'd0, 8'h00, 8'h44}, // R5 hit shared-owner
        '{2'd1, 4'd1, 8'h55, 1'b0, 8'h00, 2'd2, 8'h55, 8'h00}, // R8 update, nobody shares
        '{2'd1, 4'd1, 8'h66, 1'b0, 8'h00, 2'd0, 8'h00, 8'h00}, // R7 modified write silent
        '{2'd0, 4'd5, 8'h00, 1'b0, 8'h77, 2'd3, 8'h66, 8'h77}, // R11 dirty victim first
        '{2'd2, 4'd5, 8'h00, 1'b0, 8'h00, 2'd0, 8'h00, 8'h00}, // R10 evict exclusive silent
        '{2'd1, 4'd2, 8'h88, 1'b1, 8'h80, 2'd1, 8'h00, 8'h00}  // R11 write miss fills first
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // issue one processor op; act as bus and memory; optional snoop in eval cycle
    task automatic do_op(input logic [1:0] op, input logic [3:0] a,
                         input logic [7:0] wd, input logic sh, input logic [7:0] rd,
                         input bit coll, input logic [3:0] ca, input logic [7:0] cd,
                         output logic [1:0] fcmd, output logic [7:0] fbd,
                         output int ncmd, output logic [7:0] rdat, output bit ok);
        int hold;
        logic [1:0] pcmd;
        logic [3:0] paddr;
        logic [7:0] pdata;
        hold = 0;
        ncmd = 0;
        fcmd = 2'd0;
        fbd = '0;
        rdat = '0;
        ok = 1'b0;
        pcmd = '0;
        paddr = '0;
        pdata = '0;
        @(negedge clk);
        cpu_req = 1'b1;
        cpu_op = op;
        cpu_addr = a;
        cpu_wdata = wd;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (i == 0) begin
                cpu_req = 1'b0;
                if (coll) begin
                    sn_cmd = 2'd2;
                    sn_addr = ca;
                    sn_data = cd;
                end
            end
            if (i == 1) sn_cmd = 2'd0;
            if (cpu_done) begin
                rdat = cpu_rdata;
                ok = 1'b1;
                break;
            end
            if (bm_ack) begin
                bm_ack = 1'b0;
                hold = 0;
            end else if (bm_cmd != 2'd0) begin
                if (hold == 0) begin
                    if (ncmd == 0) begin
                        fcmd = bm_cmd;
                        fbd = bm_data;
                    end
                    ncmd++;
                end else begin
                    // R13: held until acknowledged
                    chk(bm_cmd == pcmd && bm_addr == paddr && bm_data == pdata,
                        "R13", "bus command held", {bm_cmd, bm_addr, bm_data},
                        {pcmd, paddr, pdata});
                end
                pcmd = bm_cmd;
                paddr = bm_addr;
                pdata = bm_data;
                hold++;
                if (hold == 2) begin
                    bm_ack = 1'b1;
                    bm_shared = sh;
                    bm_rdata = rd;
                end
            end
        end
        bm_ack = 1'b0;
    endtask

    task automatic probe(input logic [1:0] c, input logic [3:0] a, input logic [7:0] d,
                         output logic sh, output logic sup, output logic [7:0] sd);
        @(negedge clk);
        sn_cmd = c;
        sn_addr = a;
        sn_data = d;
        #1;
        sh = sn_shared;
        sup = sn_supply;
        sd = sn_sdata;
        @(negedge clk);
        sn_cmd = 2'd0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [1:0] fcmd;
        logic [7:0] fbd;
        logic [7:0] rdat;
        int ncmd;
        bit ok;
        logic psh, psup;
        logic [7:0] psd;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(bm_cmd == 2'd0, "R1", "bm_cmd after reset", bm_cmd, 0);
        chk(cpu_done == 1'b0, "R1", "cpu_done after reset", cpu_done, 0);
        probe(2'd1, 4'd1, 8'h00, psh, psup, psd);
        chk(psh == 1'b0, "R1", "sn_shared empty cache", psh, 0);

        foreach (VEC[k]) begin
            do_op(VEC[k].op, VEC[k].addr, VEC[k].wd, VEC[k].sh, VEC[k].rd,
                  1'b0, 4'd0, 8'h00, fcmd, fbd, ncmd, rdat, ok);
            chk(ok, "R1", $sformatf("row %0d completes", k), ok, 1);
            chk(fcmd == VEC[k].ecmd && (VEC[k].ecmd != 2'd0 || ncmd == 0),
                "R2", $sformatf("row %0d first bus cmd (R4 R7 R10 R11)", k),
                fcmd, VEC[k].ecmd);
            if (VEC[k].ecmd == 2'd2 || VEC[k].ecmd == 2'd3)
                chk(fbd == VEC[k].ebd, "R4", $sformatf("row %0d bus word (R10)", k),
                    fbd, VEC[k].ebd);
            if (VEC[k].op == 2'd0)
                chk(rdat == VEC[k].erd, "R5", $sformatf("row %0d read word", k),
                    rdat, VEC[k].erd);
        end
        chk(ncmd == 2, "R11", "write miss then update count", ncmd, 2);

        // R6 R14: owner answers snooped read
        probe(2'd1, 4'd2, 8'h00, psh, psup, psd);
        chk(psh && psup, "R6", "owner shared+supply", {psh, psup}, 3);
        chk(psd == 8'h88, "R6", "owner supplied word", psd, 8'h88);

        // R9: snooped update merges and hands ownership away
        probe(2'd2, 4'd2, 8'h99, psh, psup, psd);
        chk(psh == 1'b1, "R14", "sn_shared on update hit", psh, 1);
        do_op(2'd0, 4'd2, 8'h00, 1'b0, 8'h00, 1'b0, 4'd0, 8'h00, fcmd, fbd, ncmd, rdat, ok);
        chk(ncmd == 0 && rdat == 8'h99, "R9", "merged word read quietly", rdat, 8'h99);
        probe(2'd1, 4'd2, 8'h00, psh, psup, psd);
        chk(psh && !psup, "R9", "former owner no longer supplies", {psh, psup}, 2);

        // R14: tag mismatch
        probe(2'd1, 4'd6, 8'h00, psh, psup, psd);
        chk(psh == 1'b0, "R14", "tag mismatch not shared", psh, 0);

        // R3: exclusive line drops to shared-clean on snooped read
        do_op(2'd0, 4'd3, 8'h00, 1'b0, 8'h30, 1'b0, 4'd0, 8'h00, fcmd, fbd, ncmd, rdat, ok);
        chk(fcmd == 2'd1 && rdat == 8'h30, "R2", "exclusive fill", rdat, 8'h30);
        probe(2'd1, 4'd3, 8'h00, psh, psup, psd);
        chk(psh && !psup, "R3", "clean holder shares, no supply", {psh, psup}, 2);
        do_op(2'd1, 4'd3, 8'hA1, 1'b1, 8'h00, 1'b0, 4'd0, 8'h00, fcmd, fbd, ncmd, rdat, ok);
        chk(fcmd == 2'd2 && fbd == 8'hA1, "R3", "write after demotion broadcasts", fcmd, 2);

        // R12: peer update hits pending read in its evaluation cycle
        do_op(2'd0, 4'd3, 8'h00, 1'b0, 8'h00, 1'b1, 4'd3, 8'hC3, fcmd, fbd, ncmd, rdat, ok);
        chk(ok && ncmd == 0 && rdat == 8'hC3, "R12", "read sees peer word", rdat, 8'hC3);
        probe(2'd1, 4'd3, 8'h00, psh, psup, psd);
        chk(!psup, "R12", "ownership moved to peer", psup, 0);

        // R6: modified line becomes shared-owner on snooped read
        do_op(2'd1, 4'd0, 8'h5A, 1'b0, 8'h00, 1'b0, 4'd0, 8'h00, fcmd, fbd, ncmd, rdat, ok);
        chk(ncmd == 1 && fcmd == 2'd1, "R11", "write miss single fill", ncmd, 1);
        probe(2'd1, 4'd0, 8'h00, psh, psup, psd);
        chk(psup && psd == 8'h5A, "R6", "modified supplies", psd, 8'h5A);
        do_op(2'd1, 4'd0, 8'h6B, 1'b1, 8'h00, 1'b0, 4'd0, 8'h00, fcmd, fbd, ncmd, rdat, ok);
        chk(fcmd == 2'd2 && fbd == 8'h6B, "R6", "owner write broadcasts", fbd, 8'h6B);

        // R10: evict owner writes back, evict shared-clean silent
        do_op(2'd2, 4'd0, 8'h00, 1'b0, 8'h00, 1'b0, 4'd0, 8'h00, fcmd, fbd, ncmd, rdat, ok);
        chk(fcmd == 2'd3 && fbd == 8'h6B, "R10", "owner evict writes back", fbd, 8'h6B);
        do_op(2'd2, 4'd3, 8'h00, 1'b0, 8'h00, 1'b0, 4'd0, 8'h00, fcmd, fbd, ncmd, rdat, ok);
        chk(ok && ncmd == 0, "R10", "shared-clean evict silent", ncmd, 0);
        probe(2'd1, 4'd3, 8'h00, psh, psup, psd);
        chk(psh == 1'b0, "R10", "evicted line gone", psh, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule